// File: doc/BRIEF.md
# SMBus Slave Byte Engine with Acknowledge-Phase Interrupts

This block is the byte-level datapath of an SMBus target. It watches the open-drain clock and data lines, finds START and STOP conditions, and shifts one address or data byte at a time, most significant bit first. It samples SDA on each SCL rising edge and changes SDA only while SCL is low. After each byte it raises one interrupt towards software. While that interrupt is pending it holds SCL low, stretching the low phase of the clock until software has dealt with the byte.

Where the interrupt falls depends on who is sending and on the hardware acknowledge setting. With hardware acknowledge on, the block matches its own 7-bit address and acknowledges by itself, both for a matching address and for the data bytes that follow it. It then interrupts after the acknowledge bit. With hardware acknowledge off, a byte the block receives (address or data) interrupts before the acknowledge bit, so that software can choose the answer to drive. A byte the block sends always interrupts after the acknowledge bit, so that software can read the answer from the bus controller. Clock generation and arbitration belong elsewhere.

Top module: `smbus_byte_engine`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull` and `irq` are 0 and `status` is 0.
- R2: With `hw_ack_en`=1, an address byte whose upper 7 bits equal `own_addr` is acknowledged by the block (SDA low in the 9th clock). No interrupt is raised before that clock. The interrupt comes after it, with `status` = 4'b0110 for a write (bit0 = R/W) and 4'b0111 for a read.
- R3: With `hw_ack_en`=1, a non-matching address is not acknowledged and raises no interrupt. Further bytes are ignored until the next START.
- R4: With `hw_ack_en`=0, a received byte raises `irq` after its 8th bit and before the acknowledge clock. After `irq_clr`, the block drives ACK in the 9th clock when `ack_out`=1 and leaves SDA released when `ack_out`=0. After a NACK the session ends.
- R5: With `hw_ack_en`=0, every address byte interrupts before its acknowledge clock, whether or not it matches. `rx_data` then holds the full address byte, `status[1]`=1 and `status[0]` equals its R/W bit.
- R6: A byte the block transmits interrupts only after its acknowledge clock. `status[2]` is 1 if the bus controller drove SDA low in that clock (ACK) and 0 if not (NACK). `status[1]`=0 and `status[0]`=1.
- R7: Transmitted bytes are taken from `tx_data` at `irq_clr` (or at the read-address `irq_clr` when hardware acknowledge is off) and appear on SDA MSB first.
- R8: `scl_pull` is 1 for as long as `irq` is 1. `irq` stays set until `irq_clr` and falls on it, which releases SCL.
- R9: Received data bytes appear in `rx_data` MSB first. With `hw_ack_en`=1 they are acknowledged automatically and interrupt after the ACK, with `status[1]`=0.
- R10: A STOP (SDA rising while SCL is high) sets `status[3]` and ends the session. A START (SDA falling while SCL is high) clears `status[3]` and restarts bit counting at an address byte, even in the middle of a byte.
- R11: After the bus controller answers a transmitted byte with NACK, the block drives SDA no more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own 7-bit address for hardware matching |
| hw_ack_en | input | 1 | 1 enables address match and automatic ACK |
| tx_data | input | 8 | Next byte to transmit, taken at `irq_clr` |
| ack_out | input | 1 | Software answer for a received byte, 1 = ACK |
| irq_clr | input | 1 | Pulse that clears the pending interrupt |
| rx_data | output | 8 | Last received address or data byte |
| irq | output | 1 | Per-byte interrupt |
| status | output | 4 | {stop seen, ACK seen in 9th clock, byte was address, block transmits} |

## Verification
The assertions assume that the external bus controller keeps SCL low and high for many system clocks per phase, well beyond the synchronizer delay. They also assume that it changes SDA only while SCL is low, except when it makes a START or STOP. They further assume that software pulses `irq_clr` only while SCL is held low and never issues a STOP with an interrupt pending. The bench's bus controller holds every phase for 16 cycles and waits for SCL to read high before it continues. Every software action runs while the block is stretching the clock, and a STOP comes only after the last interrupt has been cleared.

// File: rtl/smbus_byte_engine.sv
module smbus_byte_engine #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic [6:0] own_addr,
  input  logic       hw_ack_en,
  input  logic [7:0] tx_data,
  input  logic       ack_out,
  input  logic       irq_clr,
  output logic [7:0] rx_data,
  output logic       irq,
  output logic [3:0] status
);

  typedef enum logic [1:0] {PH_ADDR, PH_RX, PH_TX} phase_t;

  logic [SYNC_STAGES:0] scl_q, sda_q;
  logic scl_s, sda_s, scl_p, sda_p;
  logic rise, fall, start_c, stop_c;

  phase_t     phase, nxt_phase;
  logic       active, dir, ack_seen, st_addr, stop_seen, pre_ack, drop_pend;
  logic [3:0] cnt;
  logic [7:0] rsh, txsh;

  assign scl_s   = scl_q[SYNC_STAGES-1];
  assign sda_s   = sda_q[SYNC_STAGES-1];
  assign scl_p   = scl_q[SYNC_STAGES];
  assign sda_p   = sda_q[SYNC_STAGES];
  assign rise    = scl_s & ~scl_p;
  assign fall    = ~scl_s & scl_p;
  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;

  assign scl_pull = irq;
  assign status   = {stop_seen, ack_seen, st_addr, dir};

  always_comb begin
    nxt_phase = phase;
    if (phase == PH_ADDR) nxt_phase = dir ? PH_TX : PH_RX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-1:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_ADDR;
      active    <= 1'b0;
      cnt       <= '0;
      rsh       <= '0;
      txsh      <= '0;
      dir       <= 1'b0;
      ack_seen  <= 1'b0;
      st_addr   <= 1'b0;
      stop_seen <= 1'b0;
      pre_ack   <= 1'b0;
      drop_pend <= 1'b0;
      irq       <= 1'b0;
      sda_pull  <= 1'b0;
      rx_data   <= '0;
    end else begin
      if (start_c) begin
        active    <= 1'b1;
        phase     <= PH_ADDR;
        cnt       <= '0;
        sda_pull  <= 1'b0;
        stop_seen <= 1'b0;
        drop_pend <= 1'b0;
      end else if (stop_c) begin
        active    <= 1'b0;
        sda_pull  <= 1'b0;
        stop_seen <= 1'b1;
      end else if (active && rise) begin
        if (cnt < 4'd8) begin
          rsh <= {rsh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (cnt == 4'd8) begin
          ack_seen <= ~sda_s;
          cnt      <= 4'd9;
        end
      end else if (active && fall) begin
        if (cnt >= 4'd1 && cnt <= 4'd7) begin
          if (phase == PH_TX) begin
            txsh     <= {txsh[6:0], 1'b0};
            sda_pull <= ~txsh[6];
          end
        end else if (cnt == 4'd8) begin
          if (phase == PH_TX) begin
            sda_pull <= 1'b0;
          end else begin
            rx_data <= rsh;
            if (phase == PH_ADDR) dir <= rsh[0];
            if (hw_ack_en) begin
              if (phase != PH_ADDR || rsh[7:1] == own_addr) sda_pull <= 1'b1;
              else active <= 1'b0;
            end else begin
              irq     <= 1'b1;
              pre_ack <= 1'b1;
              st_addr <= (phase == PH_ADDR);
            end
          end
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (drop_pend) begin
            active    <= 1'b0;
            sda_pull  <= 1'b0;
            drop_pend <= 1'b0;
          end else begin
            phase <= nxt_phase;
            if (phase == PH_TX && !ack_seen) active <= 1'b0;
            if (hw_ack_en || phase == PH_TX) begin
              irq      <= 1'b1;
              pre_ack  <= 1'b0;
              st_addr  <= (phase == PH_ADDR);
              sda_pull <= 1'b0;
            end else begin
              sda_pull <= (nxt_phase == PH_TX) ? ~txsh[7] : 1'b0;
            end
          end
        end
      end

      if (irq && irq_clr) begin
        irq <= 1'b0;
        if (pre_ack) begin
          sda_pull  <= ack_out;
          drop_pend <= ~ack_out;
          if (st_addr && dir && ack_out) txsh <= tx_data;
        end else if (active && phase == PH_TX) begin
          txsh     <= tx_data;
          sda_pull <= ~tx_data[7];
        end
      end
    end
  end

endmodule

// File: rtl/smbus_byte_engine_chk.sv
module smbus_byte_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       irq,
  input logic       irq_clr,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic [3:0] status,
  input logic [7:0] rx_data
);

  p_stretch_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_clr) |=> !scl_pull);

  p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> ($stable(status) && $stable(rx_data)));

  p_irq_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !scl_i);

  p_sda_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_i));

endmodule

bind smbus_byte_engine smbus_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .irq(irq), .irq_clr(irq_clr),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .status(status), .rx_data(rx_data)
);

// File: tb/test_smbus_byte_engine.sv
`timescale 1ns/1ps
module test_smbus_byte_engine;
  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h5B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl, sda;
  logic scl_pull, sda_pull, irq, irq_clr = 1'b0, ack_out = 1'b0, hw_ack_en = 1'b1;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic [3:0] status;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  assign scl = scl_m & ~scl_pull;
  assign sda = sda_m & ~sda_pull;

  smbus_byte_engine i_smbus_byte_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(OWN),
    .hw_ack_en(hw_ack_en), .tx_data(tx_data), .ack_out(ack_out),
    .irq_clr(irq_clr), .rx_data(rx_data), .irq(irq), .status(status)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles exp <150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; wt(H);
    scl_m = 1'b1;
    while (scl !== 1'b1) wt(1);
    wt(H/2);
    s = sda;
    wt(H/2);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
  endtask

  task automatic ack_slot(output logic acked);
    logic s;
    clock_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic service();
    irq_clr = 1'b1; wt(1);
    irq_clr = 1'b0; wt(2);
  endtask

  task automatic t_reset();
    chk("R1 scl_pull", {15'd0, scl_pull}, 16'd0);
    chk("R1 sda_pull", {15'd0, sda_pull}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 status", {12'd0, status}, 16'd0);
  endtask

  task automatic t_hw_write();
    logic a;
    hw_ack_en = 1'b1;
    bus_start();
    send_byte({OWN, 1'b0});
    chk("R2 no irq before ack", {15'd0, irq}, 16'd0);
    ack_slot(a);
    chk("R2 address acked", {15'd0, a}, 16'd1);
    chk("R2 irq after ack", {15'd0, irq}, 16'd1);
    chk("R2 status", {12'd0, status}, 16'h0006);
    scl_m = 1'b1; wt(8);
    chk("R8 scl held low", {15'd0, scl}, 16'd0);
    scl_m = 1'b0;
    service();
    chk("R8 scl released", {15'd0, scl_pull}, 16'd0);
    send_byte(8'hA5);
    chk("R9 no irq before ack", {15'd0, irq}, 16'd0);
    ack_slot(a);
    chk("R9 data acked", {15'd0, a}, 16'd1);
    chk("R9 irq", {15'd0, irq}, 16'd1);
    chk("R9 rx_data", {8'd0, rx_data}, 16'h00A5);
    chk("R9 status", {12'd0, status}, 16'h0004);
    service();
    bus_stop();
    chk("R10 stop flag", {15'd0, status[3]}, 16'd1);
    chk("R10 sda released", {15'd0, sda_pull}, 16'd0);
  endtask

  task automatic t_hw_mismatch();
    logic a;
    hw_ack_en = 1'b1;
    bus_start();
    send_byte({OWN ^ 7'h01, 1'b0});
    ack_slot(a);
    chk("R3 no ack", {15'd0, a}, 16'd0);
    chk("R3 no irq", {15'd0, irq}, 16'd0);
    send_byte(8'h00);
    ack_slot(a);
    chk("R3 data ignored", {15'd0, a}, 16'd0);
    chk("R3 still no irq", {15'd0, irq}, 16'd0);
    bus_stop();
  endtask

  task automatic t_sw_write();
    logic a;
    hw_ack_en = 1'b0;
    bus_start();
    send_byte({7'h13, 1'b0});
    chk("R5 irq before ack", {15'd0, irq}, 16'd1);
    chk("R5 rx_data", {8'd0, rx_data}, 16'h0026);
    chk("R5 status addr/dir", {14'd0, status[1:0]}, 16'h0002);
    ack_out = 1'b1;
    service();
    ack_slot(a);
    chk("R4 sw ack driven", {15'd0, a}, 16'd1);
    chk("R4 no irq after ack", {15'd0, irq}, 16'd0);
    send_byte(8'h3C);
    chk("R4 data irq before ack", {15'd0, irq}, 16'd1);
    chk("R4 data rx", {8'd0, rx_data}, 16'h003C);
    chk("R4 status data", {14'd0, status[1:0]}, 16'h0000);
    ack_out = 1'b0;
    service();
    ack_slot(a);
    chk("R4 sw nack", {15'd0, a}, 16'd0);
    send_byte(8'hFF);
    chk("R4 session ended", {15'd0, irq}, 16'd0);
    bus_stop();
  endtask

  task automatic t_hw_read();
    logic a, s;
    logic [7:0] b;
    hw_ack_en = 1'b1;
    bus_start();
    send_byte({OWN, 1'b1});
    ack_slot(a);
    chk("R2 read addr acked", {15'd0, a}, 16'd1);
    chk("R2 read status", {12'd0, status}, 16'h0007);
    tx_data = 8'hC3;
    service();
    recv_byte(b);
    chk("R7 byte 1", {8'd0, b}, 16'h00C3);
    chk("R6 no irq before ack", {15'd0, irq}, 16'd0);
    clock_bit(1'b0, s);
    chk("R6 irq after ack", {15'd0, irq}, 16'd1);
    chk("R6 status ack", {12'd0, status}, 16'h0005);
    tx_data = 8'h5A;
    service();
    recv_byte(b);
    chk("R7 byte 2", {8'd0, b}, 16'h005A);
    clock_bit(1'b1, s);
    chk("R6 irq on nack", {15'd0, irq}, 16'd1);
    chk("R6 status nack", {12'd0, status}, 16'h0001);
    tx_data = 8'h00;
    service();
    recv_byte(b);
    chk("R11 no drive after nack", {8'd0, b}, 16'h00FF);
    bus_stop();
  endtask

  task automatic t_sw_read();
    logic a, s;
    logic [7:0] b;
    hw_ack_en = 1'b0;
    bus_start();
    send_byte({OWN, 1'b1});
    chk("R5 read addr irq before ack", {15'd0, irq}, 16'd1);
    chk("R5 read status", {14'd0, status[1:0]}, 16'h0003);
    ack_out = 1'b1;
    tx_data = 8'h96;
    service();
    ack_slot(a);
    chk("R4 read addr acked", {15'd0, a}, 16'd1);
    chk("R6 no irq at addr ack", {15'd0, irq}, 16'd0);
    recv_byte(b);
    chk("R7 byte from addr clear", {8'd0, b}, 16'h0096);
    clock_bit(1'b1, s);
    chk("R6 tx irq after ack", {15'd0, irq}, 16'd1);
    chk("R6 nack seen", {15'd0, status[2]}, 16'd0);
    service();
    bus_stop();
  endtask

  task automatic t_restart();
    logic a, s;
    hw_ack_en = 1'b1;
    bus_start();
    chk("R10 start clears stop", {15'd0, status[3]}, 16'd0);
    send_byte({OWN, 1'b0});
    ack_slot(a);
    service();
    clock_bit(1'b0, s);
    clock_bit(1'b1, s);
    clock_bit(1'b0, s);
    bus_start();
    send_byte({OWN, 1'b0});
    ack_slot(a);
    chk("R10 restart addr acked", {15'd0, a}, 16'd1);
    chk("R10 restart status", {12'd0, status}, 16'h0006);
    chk("R10 restart rx", {8'd0, rx_data}, {8'd0, OWN, 1'b0});
    service();
    bus_stop();
  endtask

  initial begin
    wt(3);
    t_reset();
    rst_n = 1'b1;
    wt(5);
    t_hw_write();
    t_hw_mismatch();
    t_sw_write();
    t_hw_read();
    t_sw_read();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule